// File: doc/BRIEF.md
# Strap-Latched Pin Multiplexing Controller

This block shares a bank of device pads among several on-chip functions. Each pad is driven by one function at a time. The choices are a general-purpose I/O function, a primary function, a secondary function and a tertiary function. For every pad the block picks the output value and the output enable from the function that owns the pad. It sends the pad's input level to that function alone.

While reset is held, the block samples a set of configuration strap inputs and loads them into its configuration register. Reset therefore leaves the pads in the routing that the board wiring chose. After reset, software can rewrite the register through a small word-wide write/read port and change pad roles while the device runs. If the written enables ask for two functions on one pad, a fixed priority settles the conflict and a sticky status bit records it.

The pads fall into four groups:
- Pads 0..18 carry the upper memory address bits. A memory address field and a serial-link width field divide these pads between them.
- Pads 19..34 are the shared data lines.
- Pads 35..38 are the read/write/ready control lines.
- Pads 39..40 are the chip selects.

Top module: `strap_pinmux`

## Requirements
- R1: While rstN is low, the configuration register loads every cycle from the straps. strapAddrWidth goes to the address width, strapStorageEn to the storage enable, strapLinkEn and strapLinkWidth to the link fields. The host enable is set exactly when strapBootSel equals binary 10. The contention bit clears.
- R2: A write to word 0 (busAddr=0) loads the configuration at the next rising edge, and the pad routing follows right after that edge. A read of word 0 returns the configuration with this layout: bits 4:0 address width, bit 5 storage enable, bit 6 host enable, bit 7 link enable, bits 9:8 link width, all other bits zero.
- R3: On address pad i (0..18), with no link claim, the secondary function (memory address) owns the pad when i < address width. Otherwise the pad falls back to GPIO.
- R4: When link enable is set, the link claims the top 2, 4, 8 or 8 address pads for link width 0, 1, 2 or 3, from pad 18 downward. The claimed pads go to the tertiary function, which beats the address function.
- R5: On data and control pads (19..38), storage enable hands the pad to the secondary function. With neither storage nor host enabled, the pad stays with the primary (memory) function.
- R6: Host enable hands data, control and chip-select pads (19..40) to the tertiary function, above storage. Chip selects otherwise stay primary.
- R7: padOut and padOe come from the owning function's output and enable in the same cycle. Only the owning function's input sees padIn. Every other function input reads 0.
- R8: Bit 0 of word 1 is a sticky contention flag. It sets on the edge after any pad has two functions requested (link and address on one pad, or host and storage together). Writing 1 to it clears it, unless a conflict is still present on that edge. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous power-on reset; straps are sampled while low |
| strapAddrWidth | input | 5 | Strap: number of address pads kept as memory address |
| strapBootSel | input | 2 | Strap: boot select; binary 10 enables the host function |
| strapStorageEn | input | 1 | Strap: storage-interface enable |
| strapLinkEn | input | 1 | Strap: serial-link enable |
| strapLinkWidth | input | 2 | Strap: serial-link width code |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 1 | Register word select (0 configuration, 1 status) |
| busWdata | input | 16 | Register write data |
| busRdata | output | 16 | Register read data for busAddr |
| gpioOut | input | 41 | GPIO output values, one per pad |
| gpioOe | input | 41 | GPIO output enables |
| gpioIn | output | 41 | Pad inputs delivered to GPIO |
| priOut | input | 41 | Primary-function output values |
| priOe | input | 41 | Primary-function output enables |
| priIn | output | 41 | Pad inputs delivered to the primary function |
| secOut | input | 41 | Secondary-function output values |
| secOe | input | 41 | Secondary-function output enables |
| secIn | output | 41 | Pad inputs delivered to the secondary function |
| terOut | input | 41 | Tertiary-function output values |
| terOe | input | 41 | Tertiary-function output enables |
| terIn | output | 41 | Pad inputs delivered to the tertiary function |
| padIn | input | 41 | Levels seen at the pads |
| padOut | output | 41 | Values driven to the pads |
| padOe | output | 41 | Output enables to the pads |

## Verification
The assertions assume the straps are stable and known during the last reset cycle. They also assume busAddr and busWdata are known whenever busWe is high, and that reset lasts at least one clock edge before it is released. The bench meets these conditions by setting the straps before it drops rstN and by holding them through release. It drives bus fields only on falling edges, together with the write strobe. Conflicting enables are written on purpose so that the sticky flag's set-over-clear rule is exercised.

// File: rtl/strap_pinmux_pkg.sv
package strap_pinmux_pkg;

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_PRI  = 2'd1,
    FN_SEC  = 2'd2,
    FN_TER  = 2'd3
  } pinFn_e;

  // Field order is the software-visible layout of configuration word 0.
  typedef struct packed {
    logic [1:0] linkWidth;
    logic       linkEn;
    logic       hostEn;
    logic       storageEn;
    logic [4:0] addrWidth;
  } muxCfg_t;

  localparam int CFG_BITS = $bits(muxCfg_t);
  localparam logic [1:0] BOOT_HOST = 2'b10;
  localparam logic WORD_CFG  = 1'b0;
  localparam logic WORD_STAT = 1'b1;

  // Pads claimed by the serial link (transmit plus receive lanes).
  function automatic logic [3:0] linkClaim(input logic [1:0] widthCode);
    case (widthCode)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/strap_pinmux_ctrl.sv
module strap_pinmux_ctrl
  import strap_pinmux_pkg::*;
#(
  parameter int ADDR_PINS = 19,
  parameter int DATA_PINS = 16,
  parameter int CTRL_PINS = 4,
  parameter int CS_PINS   = 2,
  parameter int REG_W     = 16,
  localparam int NUM_PINS = ADDR_PINS + DATA_PINS + CTRL_PINS + CS_PINS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [4:0]           strapAddrWidth,
  input  logic [1:0]           strapBootSel,
  input  logic                 strapStorageEn,
  input  logic                 strapLinkEn,
  input  logic [1:0]           strapLinkWidth,
  input  logic                 busWe,
  input  logic                 busAddr,
  input  logic [REG_W-1:0]     busWdata,
  output logic [REG_W-1:0]     busRdata,
  output pinFn_e [NUM_PINS-1:0] pinSel
);

  localparam int SHARED_LO = ADDR_PINS;
  localparam int SHARED_HI = ADDR_PINS + DATA_PINS + CTRL_PINS;

  muxCfg_t cfgQ;
  muxCfg_t strapCfg;
  logic    contentionQ;
  logic    wrCfg, wrStat, clearReq;
  logic [NUM_PINS-1:0] conflictVec;
  logic    anyConflict;
  logic [3:0] claimPins;

  always_comb begin
    strapCfg.addrWidth = strapAddrWidth;
    strapCfg.storageEn = strapStorageEn;
    strapCfg.hostEn    = (strapBootSel == BOOT_HOST);
    strapCfg.linkEn    = strapLinkEn;
    strapCfg.linkWidth = strapLinkWidth;
  end

  assign wrCfg    = busWe && (busAddr == WORD_CFG);
  assign wrStat   = busWe && (busAddr == WORD_STAT);
  assign clearReq = wrStat && busWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= strapCfg;
    else if (wrCfg) cfgQ <= muxCfg_t'(busWdata[CFG_BITS-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) contentionQ <= 1'b0;
    else if (anyConflict) contentionQ <= 1'b1;
    else if (clearReq) contentionQ <= 1'b0;
  end

  assign claimPins = linkClaim(cfgQ.linkWidth);

  // Address pads: link (tertiary) over memory address (secondary) over GPIO.
  for (genvar i = 0; i < ADDR_PINS; i++) begin : g_addr
    logic terReq, secReq;
    assign terReq = cfgQ.linkEn && ((i + int'(claimPins)) >= ADDR_PINS);
    assign secReq = int'(cfgQ.addrWidth) > i;
    assign pinSel[i] = terReq ? FN_TER : (secReq ? FN_SEC : FN_GPIO);
    assign conflictVec[i] = terReq && secReq;
  end

  // Data and control pads: host over storage over memory.
  for (genvar i = SHARED_LO; i < SHARED_HI; i++) begin : g_shared
    assign pinSel[i] = cfgQ.hostEn ? FN_TER : (cfgQ.storageEn ? FN_SEC : FN_PRI);
    assign conflictVec[i] = cfgQ.hostEn && cfgQ.storageEn;
  end

  // Chip selects: host over memory.
  for (genvar i = SHARED_HI; i < NUM_PINS; i++) begin : g_cs
    assign pinSel[i] = cfgQ.hostEn ? FN_TER : FN_PRI;
    assign conflictVec[i] = 1'b0;
  end

  assign anyConflict = |conflictVec;

  always_comb begin
    busRdata = '0;
    if (busAddr == WORD_CFG) busRdata[CFG_BITS-1:0] = cfgQ;
    else busRdata[0] = contentionQ;
  end

  // R1: the first cycle out of reset shows the straps of the last reset cycle
  assert_strap_capture_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgQ.addrWidth == $past(strapAddrWidth)) &&
                    (cfgQ.hostEn == ($past(strapBootSel) == BOOT_HOST)) &&
                    (cfgQ.linkWidth == $past(strapLinkWidth)));

  assert_write_apply_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrCfg |=> (cfgQ == $past(busWdata[CFG_BITS-1:0])));

  assert_conflict_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyConflict |=> contentionQ);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (contentionQ && !clearReq) |=> contentionQ);

endmodule

// File: rtl/strap_pinmux_datapath.sv
module strap_pinmux_datapath
  import strap_pinmux_pkg::*;
#(
  parameter int   NUM_PINS   = 41,
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pinFn_e [NUM_PINS-1:0] pinSel,
  input  logic [NUM_PINS-1:0]  gpioOut,
  input  logic [NUM_PINS-1:0]  gpioOe,
  input  logic [NUM_PINS-1:0]  priOut,
  input  logic [NUM_PINS-1:0]  priOe,
  input  logic [NUM_PINS-1:0]  secOut,
  input  logic [NUM_PINS-1:0]  secOe,
  input  logic [NUM_PINS-1:0]  terOut,
  input  logic [NUM_PINS-1:0]  terOe,
  input  logic [NUM_PINS-1:0]  padIn,
  output logic [NUM_PINS-1:0]  padOut,
  output logic [NUM_PINS-1:0]  padOe,
  output logic [NUM_PINS-1:0]  gpioIn,
  output logic [NUM_PINS-1:0]  priIn,
  output logic [NUM_PINS-1:0]  secIn,
  output logic [NUM_PINS-1:0]  terIn
);

  // Value and enable come from the same select, so they switch together.
  always_comb begin
    padOut = '0;
    padOe  = '0;
    gpioIn = {NUM_PINS{IDLE_LEVEL}};
    priIn  = {NUM_PINS{IDLE_LEVEL}};
    secIn  = {NUM_PINS{IDLE_LEVEL}};
    terIn  = {NUM_PINS{IDLE_LEVEL}};
    for (int i = 0; i < NUM_PINS; i++) begin
      case (pinSel[i])
        FN_GPIO: begin padOut[i] = gpioOut[i]; padOe[i] = gpioOe[i]; gpioIn[i] = padIn[i]; end
        FN_PRI:  begin padOut[i] = priOut[i];  padOe[i] = priOe[i];  priIn[i]  = padIn[i]; end
        FN_SEC:  begin padOut[i] = secOut[i];  padOe[i] = secOe[i];  secIn[i]  = padIn[i]; end
        default: begin padOut[i] = terOut[i];  padOe[i] = terOe[i];  terIn[i]  = padIn[i]; end
      endcase
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R7: at most one function input ever leaves the idle level
    assert_input_isolate_R7: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({gpioIn[i] != IDLE_LEVEL, priIn[i] != IDLE_LEVEL,
                secIn[i] != IDLE_LEVEL, terIn[i] != IDLE_LEVEL}));
  end

endmodule

// File: rtl/strap_pinmux.sv
module strap_pinmux
  import strap_pinmux_pkg::*;
#(
  parameter int ADDR_PINS = 19,
  parameter int DATA_PINS = 16,
  parameter int CTRL_PINS = 4,
  parameter int CS_PINS   = 2,
  parameter int REG_W     = 16,
  localparam int NUM_PINS = ADDR_PINS + DATA_PINS + CTRL_PINS + CS_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4:0]          strapAddrWidth,
  input  logic [1:0]          strapBootSel,
  input  logic                strapStorageEn,
  input  logic                strapLinkEn,
  input  logic [1:0]          strapLinkWidth,
  input  logic                busWe,
  input  logic                busAddr,
  input  logic [REG_W-1:0]    busWdata,
  output logic [REG_W-1:0]    busRdata,
  input  logic [NUM_PINS-1:0] gpioOut,
  input  logic [NUM_PINS-1:0] gpioOe,
  output logic [NUM_PINS-1:0] gpioIn,
  input  logic [NUM_PINS-1:0] priOut,
  input  logic [NUM_PINS-1:0] priOe,
  output logic [NUM_PINS-1:0] priIn,
  input  logic [NUM_PINS-1:0] secOut,
  input  logic [NUM_PINS-1:0] secOe,
  output logic [NUM_PINS-1:0] secIn,
  input  logic [NUM_PINS-1:0] terOut,
  input  logic [NUM_PINS-1:0] terOe,
  output logic [NUM_PINS-1:0] terIn,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);

  pinFn_e [NUM_PINS-1:0] pinSel;

  strap_pinmux_ctrl #(
    .ADDR_PINS(ADDR_PINS), .DATA_PINS(DATA_PINS), .CTRL_PINS(CTRL_PINS),
    .CS_PINS(CS_PINS), .REG_W(REG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .strapAddrWidth(strapAddrWidth), .strapBootSel(strapBootSel),
    .strapStorageEn(strapStorageEn), .strapLinkEn(strapLinkEn),
    .strapLinkWidth(strapLinkWidth),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinSel(pinSel)
  );

  strap_pinmux_datapath #(.NUM_PINS(NUM_PINS), .IDLE_LEVEL(1'b0)) u_datapath (
    .clk(clk), .rstN(rstN), .pinSel(pinSel),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .priOut(priOut), .priOe(priOe),
    .secOut(secOut), .secOe(secOe), .terOut(terOut), .terOe(terOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .gpioIn(gpioIn), .priIn(priIn), .secIn(secIn), .terIn(terIn)
  );

endmodule

// File: tb/strap_pinmux_tb.sv
module strap_pinmux_tb;

  localparam int NP = 41;
  localparam int NV = 9;

  // {expected contention, configuration word}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'h0000}, {1'b0, 16'h0013}, {1'b0, 16'h002A},
    {1'b1, 16'h009F}, {1'b0, 16'h018B}, {1'b0, 16'h0288},
    {1'b0, 16'h0040}, {1'b1, 16'h0060}, {1'b0, 16'h0385}
  };

  localparam logic [NP-1:0] G_OUT = 41'h155_5555_5555;
  localparam logic [NP-1:0] G_OE  = 41'h0FF_00FF_00FF;
  localparam logic [NP-1:0] P_OUT = 41'h0F0_F0F0_F0F0;
  localparam logic [NP-1:0] P_OE  = 41'h133_3333_3333;
  localparam logic [NP-1:0] S_OUT = 41'h0CC_CCCC_CCCC;
  localparam logic [NP-1:0] S_OE  = 41'h1E1_E1E1_E1E1;
  localparam logic [NP-1:0] T_OUT = 41'h1AA_AAAA_AAAA;
  localparam logic [NP-1:0] T_OE  = 41'h0C3_C3C3_C3C3;
  localparam logic [NP-1:0] P_IN  = 41'h1C7_1C71_C71C;

  logic clk = 1'b0;
  logic rstN;
  logic [4:0] strapAddrWidth;
  logic [1:0] strapBootSel, strapLinkWidth;
  logic strapStorageEn, strapLinkEn;
  logic busWe, busAddr;
  logic [15:0] busWdata, busRdata;
  logic [NP-1:0] gpioIn, priIn, secIn, terIn, padOut, padOe;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  strap_pinmux u_dut (
    .clk(clk), .rstN(rstN),
    .strapAddrWidth(strapAddrWidth), .strapBootSel(strapBootSel),
    .strapStorageEn(strapStorageEn), .strapLinkEn(strapLinkEn),
    .strapLinkWidth(strapLinkWidth),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .gpioOut(G_OUT), .gpioOe(G_OE), .gpioIn(gpioIn),
    .priOut(P_OUT), .priOe(P_OE), .priIn(priIn),
    .secOut(S_OUT), .secOe(S_OE), .secIn(secIn),
    .terOut(T_OUT), .terOe(T_OE), .terIn(terIn),
    .padIn(P_IN), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Owner of pad p under configuration c, taken from R3..R6.
  function automatic int expSel(input logic [15:0] c, input int p);
    int claim;
    claim = (c[9:8] == 2'd0) ? 2 : (c[9:8] == 2'd1) ? 4 : 8;
    if (p < 19) begin
      if (c[7] && p >= 19 - claim) return 3;
      if (p < int'(c[4:0])) return 2;
      return 0;
    end
    if (p < 39) return c[6] ? 3 : (c[5] ? 2 : 1);
    return c[6] ? 3 : 1;
  endfunction

  task automatic checkPads(input logic [15:0] c, input string tag);
    logic [NP-1:0] eo, ee, eg, ep, es, et;
    eo = '0; ee = '0; eg = '0; ep = '0; es = '0; et = '0;
    for (int p = 0; p < NP; p++) begin
      case (expSel(c, p))
        0: begin eo[p] = G_OUT[p]; ee[p] = G_OE[p]; eg[p] = P_IN[p]; end
        1: begin eo[p] = P_OUT[p]; ee[p] = P_OE[p]; ep[p] = P_IN[p]; end
        2: begin eo[p] = S_OUT[p]; ee[p] = S_OE[p]; es[p] = P_IN[p]; end
        default: begin eo[p] = T_OUT[p]; ee[p] = T_OE[p]; et[p] = P_IN[p]; end
      endcase
    end
    check({tag, " R3 R4 R5 R6 padOut"}, 64'(padOut), 64'(eo));
    check({tag, " R3 R4 R5 R6 padOe"}, 64'(padOe), 64'(ee));
    check({tag, " R7 gpioIn"}, 64'(gpioIn), 64'(eg));
    check({tag, " R7 priIn"}, 64'(priIn), 64'(ep));
    check({tag, " R7 secIn"}, 64'(secIn), 64'(es));
    check({tag, " R7 terIn"}, 64'(terIn), 64'(et));
  endtask

  task automatic busWrite(input logic a, input logic [15:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [15:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    logic [15:0] rd;
    rstN = 1'b0; busWe = 1'b0; busAddr = 1'b0; busWdata = '0;
    strapAddrWidth = 5'd12; strapBootSel = 2'b10; strapStorageEn = 1'b1;
    strapLinkEn = 1'b1; strapLinkWidth = 2'd1;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // Reset state, before the first edge out of reset (R1).
    readReg(1'b0, rd); check("R1 strap capture readback", 64'(rd), 64'h1EC);
    readReg(1'b1, rd); check("R1 contention clear at reset", 64'(rd), 64'h0);
    checkPads(16'h01EC, "R1 strap routing");

    // Strapped host+storage conflict raises the flag (R8).
    @(negedge clk);
    readReg(1'b1, rd); check("R8 flag set from strap conflict", 64'(rd), 64'h1);
    busWrite(1'b1, 16'h0001);
    readReg(1'b1, rd); check("R8 clear loses to live conflict", 64'(rd), 64'h1);

    // Table-driven routing sweep (R2..R8).
    for (int v = 0; v < NV; v++) begin
      busWrite(1'b0, VEC[v][15:0]);
      busWrite(1'b1, 16'h0001);
      readReg(1'b1, rd); check($sformatf("R8 vec%0d contention", v), 64'(rd), 64'(VEC[v][16]));
      readReg(1'b0, rd); check($sformatf("R2 vec%0d readback", v), 64'(rd), 64'(VEC[v][15:0] & 16'h03FF));
      checkPads(VEC[v][15:0], $sformatf("vec%0d", v));
    end

    // R2: routing changes only at the write edge.
    busWrite(1'b0, 16'h0000);
    @(negedge clk);
    busWe = 1'b1; busAddr = 1'b0; busWdata = 16'h0040;
    #0.5;
    check("R2 no change before edge", 64'(padOe), 64'(G_OE & 41'h0_0000_0000 | P_OE & 41'h1FF_FFF8_0000 | G_OE & 41'h0_0007_FFFF));
    @(negedge clk);
    busWe = 1'b0;
    checkPads(16'h0040, "R2 after edge");

    // R8: write of 0 keeps the flag, write of 1 clears it once conflict is gone.
    busWrite(1'b0, 16'h0060);
    busWrite(1'b0, 16'h0000);
    busWrite(1'b1, 16'h0000);
    readReg(1'b1, rd); check("R8 zero write keeps flag", 64'(rd), 64'h1);
    busWrite(1'b1, 16'h0001);
    readReg(1'b1, rd); check("R8 one write clears flag", 64'(rd), 64'h0);

    // R1: second reset with a non-host boot select.
    @(negedge clk);
    rstN = 1'b0;
    strapAddrWidth = 5'd19; strapBootSel = 2'b01; strapStorageEn = 1'b0;
    strapLinkEn = 1'b0; strapLinkWidth = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    readReg(1'b0, rd); check("R1 boot select 01 leaves host off", 64'(rd), 64'h013);
    checkPads(16'h0013, "R1 second strap");

    finish();
  end

endmodule